// File: doc/BRIEF.md
# Raster Timing and Video Memory Address Generator

This block drives the timing of a raster display and produces the address stream for a 32 KB video memory. A horizontal pixel counter and a vertical line counter produce horizontal sync, vertical sync, a combined blanking flag and a vertical-blank flag. A per-frame display mode chosen by four control bits sets two things. The upper pair picks the number of visible lines (200, 240, 400 or 480). The lower pair, together with that choice, picks the byte-fetch cadence of every eighth or every fourth pixel.

During visible pixels the block issues a byte-load strobe at each fetch and presents the matching memory address. The address is the row number in the upper bits and the byte column in the lower bits. An optional line-doubling input clears the low row bit, so that each odd line shows the data of the even line above it. A mode-latch strobe tells the downstream mode register when to load. In the 200- and 400-line modes it fires on the first fetch of every visible line, where that line's leading data byte carries its settings. In the 240- and 480-line modes it fires once per frame, at the start of the first blanked line.

A processor can take over the memory address bus at any time. While its request is high, its address replaces the raster address on the output in the same cycle. The counters run on unchanged, so an access during visible pixels may disturb the picture. The vertical-blank output lets software place its accesses where they cannot.

Top module: `vid_raster_addrgen`

## Requirements
- R1: While reset is high, and on the first edge with reset high, the registered outputs take blank=1, vblank=1, hsync=0, vsync=0, byte_load=0, mode_latch=0 and raster address 0.
- R2: The pixel counter repeats every H_TOTAL clocks. Outputs lag the counter by one clock. blank is high whenever the pixel count is H_ACTIVE or more. hsync is high for pixel counts from HS_START to HS_START+HS_LEN-1.
- R3: A frame is V_TOTAL lines. The visible line count is 200, 240, 400 or 480 for mode[3:2] = 0, 1, 2 or 3. vblank and blank are high on every line at or beyond it. vsync is high on lines VS_START to VS_START+VS_LEN-1, which lie inside vertical blank.
- R4: The mode input is sampled only on the clock that wraps the counters to pixel 0 of line 0. A change in the middle of a frame has no effect until the next frame.
- R5: byte_load pulses on visible pixels whose count is a multiple of 8 when mode[1:0]=0 and mode[2]=1 (the 512-wide one-bit modes 4 and 12). In every other mode it pulses on visible pixels whose count is a multiple of 4.
- R6: With no processor request, the address is {line[8:0], column[5:0]}. The column is the pixel count divided by 8 in the eight-pixel cadence and by 4 otherwise.
- R7: When the line-double input is high, bit 6 of the raster address (row bit 0) is 0.
- R8: While cpu_req is high, vram_addr equals cpu_addr in the same cycle. The timing outputs are unaffected.
- R9: When mode[2]=0 (200 and 400 lines), mode_latch pulses at pixel 0 of every visible line. When mode[2]=1, it pulses once per frame, at pixel 0 of the first blanked line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 4 | Display mode; [3:2] line count, [1:0] depth/width |
| dbl_i | input | 1 | Line-doubling enable |
| cpu_req_i | input | 1 | Processor request for the memory address bus |
| cpu_addr_i | input | 15 | Processor address |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| blank_o | output | 1 | High outside the visible area |
| vblank_o | output | 1 | High on non-visible lines |
| vram_addr_o | output | 15 | Video memory address |
| byte_load_o | output | 1 | Fetch strobe for the pixel shifter |
| mode_latch_o | output | 1 | Load strobe for the mode register |

## Verification
The assertions assume a sync window that lies wholly inside the blanking region on both axes. They also assume a line-double input that is steady for at least one clock before the address that depends on it. The bench changes every input only on the falling clock edge and keeps the default timing constants, whose sync windows fall after the last visible pixel and after line 480. Processor requests and line-double toggles come from free-running background patterns. Their effect is checked every cycle against the bench's own position model, not assumed away.

// File: rtl/vid_pkg.sv
package vid_pkg;

    localparam int MODE_W = 4;

    typedef logic [MODE_W-1:0] vmode_t;

    // Eight-pixel fetch cadence: one-bit depth at full 512-pixel width.
    function automatic logic fetch_wide(vmode_t m);
        return (m[1:0] == 2'b00) && m[2];
    endfunction

    // Modes whose settings are reloaded on every visible line.
    function automatic logic line_mode(vmode_t m);
        return !m[2];
    endfunction

endpackage

// File: rtl/vid_hv_counter.sv
module vid_hv_counter
    import vid_pkg::*;
#(
    parameter int H_TOTAL = 40,
    parameter int V_TOTAL = 525,
    localparam int H_W = $clog2(H_TOTAL),
    localparam int V_W = $clog2(V_TOTAL)
) (
    input  logic           clk_i,
    input  logic           rst_i,
    input  vmode_t         mode_i,
    output logic [H_W-1:0] h_o,
    output logic [V_W-1:0] v_o,
    output vmode_t         mode_o
);

    localparam logic [H_W-1:0] H_LAST = H_W'(H_TOTAL - 1);
    localparam logic [V_W-1:0] V_LAST = V_W'(V_TOTAL - 1);

    typedef struct packed {
        logic [H_W-1:0] h;
        logic [V_W-1:0] v;
        vmode_t         mode;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q.h == H_LAST) begin
            cnt_d.h = '0;
            if (cnt_q.v == V_LAST) begin
                cnt_d.v    = '0;
                cnt_d.mode = mode_i;   // mode held for a whole frame
            end else begin
                cnt_d.v = cnt_q.v + 1'b1;
            end
        end else begin
            cnt_d.h = cnt_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '{h: H_LAST, v: V_LAST, mode: '0};
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign h_o    = cnt_q.h;
    assign v_o    = cnt_q.v;
    assign mode_o = cnt_q.mode;

endmodule

// File: rtl/vid_out_stage.sv
module vid_out_stage
    import vid_pkg::*;
#(
    parameter int H_W      = 6,
    parameter int V_W      = 10,
    parameter int H_ACTIVE = 32,
    parameter int HS_START = 34,
    parameter int HS_LEN   = 4,
    parameter int VS_START = 490,
    parameter int VS_LEN   = 2,
    parameter int V_ACT_A  = 200,
    parameter int V_ACT_B  = 240,
    parameter int V_ACT_C  = 400,
    parameter int V_ACT_D  = 480,
    parameter int ADDR_W   = 15,
    parameter int COL_W    = 6,
    localparam int ROW_F   = ADDR_W - COL_W
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [H_W-1:0]    h_i,
    input  logic [V_W-1:0]    v_i,
    input  vmode_t            mode_i,
    input  logic              dbl_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o,
    output logic              vblank_o,
    output logic              load_o,
    output logic              latch_o,
    output logic [ADDR_W-1:0] addr_o
);

    typedef struct packed {
        logic              hsync;
        logic              vsync;
        logic              blank;
        logic              vblank;
        logic              load;
        logic              latch;
        logic [ADDR_W-1:0] addr;
    } out_t;

    out_t out_d, out_q;

    int               vact;
    logic             wide;
    logic             h_vis;
    logic             v_vis;
    logic             phase;
    logic [ROW_F-1:0] row;
    logic [COL_W-1:0] col;

    always_comb begin
        case (mode_i[3:2])
            2'd0:    vact = V_ACT_A;
            2'd1:    vact = V_ACT_B;
            2'd2:    vact = V_ACT_C;
            default: vact = V_ACT_D;
        endcase
        wide  = fetch_wide(mode_i);
        h_vis = int'(h_i) < H_ACTIVE;
        v_vis = int'(v_i) < vact;
        phase = wide ? (h_i[2:0] == 3'd0) : (h_i[1:0] == 2'd0);

        row = ROW_F'(v_i);
        if (dbl_i) begin
            row[0] = 1'b0;
        end
        col = wide ? COL_W'(h_i >> 3) : COL_W'(h_i >> 2);

        out_d.hsync  = (int'(h_i) >= HS_START) && (int'(h_i) < HS_START + HS_LEN);
        out_d.vsync  = (int'(v_i) >= VS_START) && (int'(v_i) < VS_START + VS_LEN);
        out_d.vblank = !v_vis;
        out_d.blank  = !(h_vis && v_vis);
        out_d.load   = h_vis && v_vis && phase;
        out_d.latch  = (h_i == '0) && (line_mode(mode_i) ? v_vis : (int'(v_i) == vact));
        out_d.addr   = {row, col};
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            out_q <= '{hsync: 1'b0, vsync: 1'b0, blank: 1'b1, vblank: 1'b1,
                       load: 1'b0, latch: 1'b0, addr: '0};
        end else begin
            out_q <= out_d;
        end
    end

    assign hsync_o  = out_q.hsync;
    assign vsync_o  = out_q.vsync;
    assign blank_o  = out_q.blank;
    assign vblank_o = out_q.vblank;
    assign load_o   = out_q.load;
    assign latch_o  = out_q.latch;
    assign addr_o   = out_q.addr;

endmodule

// File: rtl/vid_raster_addrgen.sv
module vid_raster_addrgen
    import vid_pkg::*;
#(
    parameter int H_ACTIVE = 32,
    parameter int H_TOTAL  = 40,
    parameter int HS_START = 34,
    parameter int HS_LEN   = 4,
    parameter int V_TOTAL  = 525,
    parameter int VS_START = 490,
    parameter int VS_LEN   = 2,
    parameter int V_ACT_A  = 200,
    parameter int V_ACT_B  = 240,
    parameter int V_ACT_C  = 400,
    parameter int V_ACT_D  = 480,
    parameter int ADDR_W   = 15,
    parameter int COL_W    = 6,
    localparam int H_W     = $clog2(H_TOTAL),
    localparam int V_W     = $clog2(V_TOTAL)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [3:0]        mode_i,
    input  logic              dbl_i,
    input  logic              cpu_req_i,
    input  logic [ADDR_W-1:0] cpu_addr_i,
    output logic              hsync_o,
    output logic              vsync_o,
    output logic              blank_o,
    output logic              vblank_o,
    output logic [ADDR_W-1:0] vram_addr_o,
    output logic              byte_load_o,
    output logic              mode_latch_o
);

    logic [H_W-1:0]    h_q;
    logic [V_W-1:0]    v_q;
    vmode_t            mode_q;
    logic [ADDR_W-1:0] raster_addr_q;

    vid_hv_counter #(
        .H_TOTAL (H_TOTAL),
        .V_TOTAL (V_TOTAL)
    ) cnt_i (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .mode_i (mode_i),
        .h_o    (h_q),
        .v_o    (v_q),
        .mode_o (mode_q)
    );

    vid_out_stage #(
        .H_W      (H_W),
        .V_W      (V_W),
        .H_ACTIVE (H_ACTIVE),
        .HS_START (HS_START),
        .HS_LEN   (HS_LEN),
        .VS_START (VS_START),
        .VS_LEN   (VS_LEN),
        .V_ACT_A  (V_ACT_A),
        .V_ACT_B  (V_ACT_B),
        .V_ACT_C  (V_ACT_C),
        .V_ACT_D  (V_ACT_D),
        .ADDR_W   (ADDR_W),
        .COL_W    (COL_W)
    ) out_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .h_i      (h_q),
        .v_i      (v_q),
        .mode_i   (mode_q),
        .dbl_i    (dbl_i),
        .hsync_o  (hsync_o),
        .vsync_o  (vsync_o),
        .blank_o  (blank_o),
        .vblank_o (vblank_o),
        .load_o   (byte_load_o),
        .latch_o  (mode_latch_o),
        .addr_o   (raster_addr_q)
    );

    // Processor override of the shared address bus, no arbitration.
    assign vram_addr_o = cpu_req_i ? cpu_addr_i : raster_addr_q;

endmodule

// File: rtl/vid_raster_addrgen_chk.sv
module vid_raster_addrgen_chk #(
    parameter int ADDR_W = 15,
    parameter int COL_W  = 6
) (
    input logic              clk_i,
    input logic              rst_i,
    input logic              dbl_i,
    input logic              cpu_req_i,
    input logic              hsync_o,
    input logic              vsync_o,
    input logic              blank_o,
    input logic              vblank_o,
    input logic [ADDR_W-1:0] vram_addr_o,
    input logic              byte_load_o,
    input logic              mode_latch_o
);

    AST_HSYNC_BLANKED: assert property (@(posedge clk_i) disable iff (rst_i)
        hsync_o |-> blank_o);                                   // R2
    AST_VSYNC_IN_VBLANK: assert property (@(posedge clk_i) disable iff (rst_i)
        vsync_o |-> vblank_o);                                  // R3
    AST_VBLANK_BLANKS: assert property (@(posedge clk_i) disable iff (rst_i)
        vblank_o |-> blank_o);                                  // R3
    AST_LOAD_VISIBLE: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_load_o |-> !blank_o);                              // R5
    AST_LOAD_SPACED: assert property (@(posedge clk_i) disable iff (rst_i)
        byte_load_o |=> !byte_load_o);                          // R5
    AST_LATCH_PLACED: assert property (@(posedge clk_i) disable iff (rst_i)
        mode_latch_o |-> (byte_load_o || vblank_o));            // R9
    AST_DOUBLE_EVEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (!cpu_req_i && $past(dbl_i) && !$past(rst_i)) |-> !vram_addr_o[COL_W]); // R7

endmodule

bind vid_raster_addrgen vid_raster_addrgen_chk #(
    .ADDR_W (ADDR_W),
    .COL_W  (COL_W)
) chk_i (
    .clk_i        (clk_i),
    .rst_i        (rst_i),
    .dbl_i        (dbl_i),
    .cpu_req_i    (cpu_req_i),
    .hsync_o      (hsync_o),
    .vsync_o      (vsync_o),
    .blank_o      (blank_o),
    .vblank_o     (vblank_o),
    .vram_addr_o  (vram_addr_o),
    .byte_load_o  (byte_load_o),
    .mode_latch_o (mode_latch_o)
);

// File: tb/vid_raster_addrgen_tb_top.sv
module vid_raster_addrgen_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int H_ACTIVE = 32;
    localparam int H_TOTAL  = 40;
    localparam int HS_START = 34;
    localparam int HS_LEN   = 4;
    localparam int V_TOTAL  = 525;
    localparam int VS_START = 490;
    localparam int VS_LEN   = 2;
    localparam int FRAME    = H_TOTAL * V_TOTAL;
    localparam int WATCHDOG = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  mode = 4'd4;
    logic        dbl = 1'b0;
    logic        cpu_req = 1'b0;
    logic [14:0] cpu_addr = '0;
    logic        hsync, vsync, blank, vblank, byte_load, mode_latch;
    logic [14:0] vram_addr;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench position model
    int m_h = H_TOTAL - 1;
    int m_v = V_TOTAL - 1;
    int m_mode = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vid_raster_addrgen dut_i (
        .clk_i        (clk),
        .rst_i        (rst),
        .mode_i       (mode),
        .dbl_i        (dbl),
        .cpu_req_i    (cpu_req),
        .cpu_addr_i   (cpu_addr),
        .hsync_o      (hsync),
        .vsync_o      (vsync),
        .blank_o      (blank),
        .vblank_o     (vblank),
        .vram_addr_o  (vram_addr),
        .byte_load_o  (byte_load),
        .mode_latch_o (mode_latch)
    );

    function automatic int lines_of(int m);
        case ((m >> 2) & 3)
            0: return 200;
            1: return 240;
            2: return 400;
            default: return 480;
        endcase
    endfunction

    function automatic int step_of(int m);
        return (((m & 3) == 0) && ((m & 4) != 0)) ? 8 : 4;
    endfunction

    task automatic cmp(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d (h=%0d v=%0d)", tag, what, act, exp, m_h, m_v);
        end
    endtask

    // per-cycle reference comparison
    initial begin
        int e_hs, e_vs, e_bl, e_vb, e_ld, e_lt, e_ra, e_ad, row, va, st;
        bit was_rst;
        forever begin
            @(posedge clk);
            was_rst = rst;
            if (was_rst) begin
                e_hs = 0; e_vs = 0; e_bl = 1; e_vb = 1; e_ld = 0; e_lt = 0; e_ra = 0;
                m_h = H_TOTAL - 1; m_v = V_TOTAL - 1; m_mode = 0;
            end else begin
                va = lines_of(m_mode);
                st = step_of(m_mode);
                e_hs = (m_h >= HS_START && m_h < HS_START + HS_LEN) ? 1 : 0;
                e_vs = (m_v >= VS_START && m_v < VS_START + VS_LEN) ? 1 : 0;
                e_vb = (m_v >= va) ? 1 : 0;
                e_bl = (m_v >= va || m_h >= H_ACTIVE) ? 1 : 0;
                e_ld = (e_bl == 0 && (m_h % st) == 0) ? 1 : 0;
                if ((m_mode & 4) == 0) e_lt = (m_h == 0 && m_v < va) ? 1 : 0;
                else                   e_lt = (m_h == 0 && m_v == va) ? 1 : 0;
                row = m_v % 512;
                if (dbl) row = row - (row % 2);
                e_ra = row * 64 + ((m_h / st) % 64);
                // advance the model position
                if (m_h == H_TOTAL - 1) begin
                    m_h = 0;
                    if (m_v == V_TOTAL - 1) begin
                        m_v = 0;
                        m_mode = int'(mode);
                    end else begin
                        m_v++;
                    end
                end else begin
                    m_h++;
                end
            end
            e_ad = cpu_req ? int'(cpu_addr) : e_ra;
            #1;
            if (was_rst) begin
                cmp("R1", "hsync", int'(hsync), e_hs);
                cmp("R1", "vsync", int'(vsync), e_vs);
                cmp("R1", "blank", int'(blank), e_bl);
                cmp("R1", "vblank", int'(vblank), e_vb);
                cmp("R1", "byte_load", int'(byte_load), e_ld);
                cmp("R1", "mode_latch", int'(mode_latch), e_lt);
                cmp("R1", "vram_addr", int'(vram_addr), e_ad);
            end else begin
                cmp("R2", "hsync", int'(hsync), e_hs);
                cmp("R3", "vsync", int'(vsync), e_vs);
                cmp("R2", "blank", int'(blank), e_bl);
                cmp("R3", "vblank", int'(vblank), e_vb);
                cmp("R5", "byte_load", int'(byte_load), e_ld);
                cmp("R9", "mode_latch", int'(mode_latch), e_lt);
                if (cpu_req)  cmp("R8", "vram_addr", int'(vram_addr), e_ad);
                else if (dbl) cmp("R7", "vram_addr", int'(vram_addr), e_ad);
                else          cmp("R6", "vram_addr", int'(vram_addr), e_ad);
            end
        end
    end

    // background processor requests and line-double toggles
    initial begin
        int t = 0;
        @(negedge clk);
        while (!done) begin
            @(negedge clk);
            t++;
            cpu_req  <= ((t % 997) < 13) && (t > 20);
            cpu_addr <= 15'((t * 37) ^ 15'h5A5A);
            if ((t % 2503) == 0) dbl <= ~dbl;
        end
    end

    // watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", WATCHDOG, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic wait_frame_start();
        do @(negedge clk); while (!(m_h == 0 && m_v == 0));
    endtask

    // counts over one frame of outputs starting after the counters wrapped
    task automatic count_frame(output int n_ld, output int n_lt, output int n_vb,
                               output int n_vs, output int n_hs);
        n_ld = 0; n_lt = 0; n_vb = 0; n_vs = 0; n_hs = 0;
        for (int i = 0; i < FRAME; i++) begin
            @(negedge clk);
            n_ld += int'(byte_load);
            n_lt += int'(mode_latch);
            n_vb += int'(vblank);
            n_vs += int'(vsync);
            n_hs += int'(hsync);
        end
    endtask

    initial begin
        int n_ld, n_lt, n_vb, n_vs, n_hs, c;
        repeat (5) @(negedge clk);
        rst = 1'b0;                         // frame A runs in mode 4
        repeat (100 * H_TOTAL) @(negedge clk);

        // R4: a mid-frame change to mode 2 keeps the eight-pixel cadence
        mode = 4'd2;
        repeat (3 * H_TOTAL) @(negedge clk);
        c = 0;
        for (int i = 0; i < H_TOTAL; i++) begin
            @(negedge clk);
            c += int'(byte_load);
        end
        cmp("R4", "loads per line after mid-frame change", c, H_ACTIVE / 8);

        // frame B: mode 2, 200 lines, per-line latch, four-pixel cadence
        wait_frame_start();
        mode = 4'd11;                       // R4: ignored until frame C
        count_frame(n_ld, n_lt, n_vb, n_vs, n_hs);
        cmp("R9", "mode-2 latches per frame", n_lt, 200);
        cmp("R5", "mode-2 loads per frame", n_ld, 200 * H_ACTIVE / 4);
        cmp("R3", "mode-2 vblank cycles", n_vb, (V_TOTAL - 200) * H_TOTAL);
        cmp("R3", "vsync cycles", n_vs, VS_LEN * H_TOTAL);
        cmp("R2", "hsync cycles", n_hs, HS_LEN * V_TOTAL);

        // frame C: mode 11, 400 lines, per-line latch
        mode = 4'd13;
        count_frame(n_ld, n_lt, n_vb, n_vs, n_hs);
        cmp("R9", "mode-11 latches per frame", n_lt, 400);
        cmp("R3", "mode-11 vblank cycles", n_vb, (V_TOTAL - 400) * H_TOTAL);

        // frame D: mode 13, 480 lines, single latch per frame
        mode = 4'd12;
        count_frame(n_ld, n_lt, n_vb, n_vs, n_hs);
        cmp("R9", "mode-13 latches per frame", n_lt, 1);
        cmp("R5", "mode-13 loads per frame", n_ld, 480 * H_ACTIVE / 4);
        cmp("R3", "mode-13 vblank cycles", n_vb, (V_TOTAL - 480) * H_TOTAL);

        // frame E: mode 12, 480 lines, eight-pixel cadence
        count_frame(n_ld, n_lt, n_vb, n_vs, n_hs);
        cmp("R5", "mode-12 loads per frame", n_ld, 480 * H_ACTIVE / 8);
        cmp("R9", "mode-12 latches per frame", n_lt, 1);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule